// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block moves bursts of bytes over a four-wire synchronous serial link with no processor help between bytes. The processor fills an eight-entry byte buffer, picks a burst length, chooses whether the serial clock is generated locally or supplied by a remote master, and pulses `start`. The port then shifts each byte out while it shifts a byte in, and stores every received byte over the entry it was sent from. When the last byte completes, `done` pulses for one cycle.

A chip-select gated mode lets the port share a bus with other devices. While the select line is inactive, the clock and data outputs are released and the burst is frozen in place. It resumes when the select line goes active again. Tri-state drivers sit outside the block and are steered by the two output-enable ports.

Top module: `sio_burst_port`

## Requirements
- R1: After a synchronous reset `busy` and `done` are 0, `sck_out` and `sdo` are 1, and every buffer entry reads 0.
- R2: A cycle with `buf_we` high stores `buf_wdata` at `buf_waddr`, and `buf_rdata` shows the entry selected by `buf_raddr` combinationally.
- R3: With `burst_len` = n (0 to 7), one accepted `start` transfers exactly n+1 bytes, from entry 0 upward, and then produces exactly one `done` pulse.
- R4: Each byte is sent most significant bit first. `sdo` changes only after a falling serial clock edge, and `sdi` is captured on the rising edge.
- R5: The byte received in slot k overwrites buffer entry k. Entries above the burst length keep their previous contents.
- R6: With `master_mode` = 1 the port drives the clock. Each low and each high phase lasts HALF_DIV system cycles (default 4), and the clock rests high when no burst runs.
- R7: With `master_mode` = 0, `sck_oe` is 0 and `sck_out` stays 1. The external `sck_in`, `cs_n_in` and `sdi` pass through a two-flop synchronizer before they are used.
- R8: With `cs_gate_en` = 1 and `cs_n_in` high, `sck_oe` and `sdo_oe` are 0 and the burst makes no progress. Once `cs_n_in` goes low, both enables return to 1 and the burst continues.
- R9: A `start` pulse while `busy` is 1 is ignored. The running burst keeps its length and its data.
- R10: `done` is high for exactly one cycle, in the same cycle that `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_we | input | 1 | Buffer write strobe |
| buf_waddr | input | 3 | Buffer write index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_raddr | input | 3 | Buffer read index |
| buf_rdata | output | 8 | Buffer read byte |
| burst_len | input | 3 | Burst length minus one |
| master_mode | input | 1 | 1: local clock generation, 0: external clock |
| cs_gate_en | input | 1 | 1: transfers gated by chip select |
| start | input | 1 | Burst start strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n_in | input | 1 | Chip select, active low |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pad |

## Verification
On every cycle the properties check the following. The completion pulse lasts one cycle and coincides with the end of `busy`. A burst begins only after a start strobe. The clock rests high whenever the port is idle or in external-clock mode. A deselected, gated port freezes both its clock and its data. The generated clock never toggles on two consecutive cycles. Bit order, the write-back of received bytes into the correct entries, the exact burst length and the pause-and-resume behaviour under chip select involve a peer on the line, so only the bench scenarios can show them.

// File: rtl/sio_pkg.sv
// Shared types for the buffered serial port.
// Assumes: nothing beyond a 1800-2017 compiler.
package sio_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sio_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sio_edge_t;
endpackage

// File: rtl/sio_buffer.sv
// Byte buffer with one processor write port, one engine write port and
// two combinational read ports.
// Assumes: DEPTH is a power of two. An engine write wins over a processor
// write to the same entry.
module sio_buffer #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_waddr,
    input  logic [WIDTH-1:0] cpu_wdata,
    input  logic [AW-1:0]    cpu_raddr,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic             eng_we,
    input  logic [AW-1:0]    eng_waddr,
    input  logic [WIDTH-1:0] eng_wdata,
    input  logic [AW-1:0]    eng_raddr,
    output logic [WIDTH-1:0] eng_rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store processor and engine bytes; the engine has priority on a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (cpu_we && !(eng_we && eng_waddr == cpu_waddr))
                mem[cpu_waddr] <= cpu_wdata;
            if (eng_we)
                mem[eng_waddr] <= eng_wdata;
        end
    end

    assign cpu_rdata = mem[cpu_raddr];
    assign eng_rdata = mem[eng_raddr];
endmodule

// File: rtl/sio_sync.sv
// Multi-flop synchronizer for N asynchronous lines.
// Assumes: each line is a level that is stable for several clock cycles.
module sio_sync #(
    parameter int           N      = 3,
    parameter int           STAGES = 2,
    parameter logic [N-1:0] INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{INIT[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sio_clkgen.sv
// Local serial clock generator: each phase lasts HALF_DIV cycles and the
// clock rests high. Ticks mark the cycle in which the clock toggles.
// Assumes: run drops only at the end of a burst. adv low freezes the phase.
module sio_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              adv,
    output logic              sck,
    output sio_pkg::sio_edge_t tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          sck_q;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF_DIV - 1));

    // Count out each phase and toggle the clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (adv) begin
            if (wrap) begin
                cnt   <= '0;
                sck_q <= ~sck_q;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign sck       = sck_q;
    assign tick.fall = run & adv & wrap & sck_q;
    assign tick.rise = run & adv & wrap & ~sck_q;
endmodule

// File: rtl/sio_burst_port.sv
// Buffered synchronous serial port: shifts 1..DEPTH bytes per start,
// MSB first, launching on falling and sampling on rising clock edges.
// Received bytes replace the sent ones in place.
// Assumes: mode inputs stay constant during a burst. The external clock
// is slow against clk (several cycles per phase).
module sio_burst_port #(
    parameter int DEPTH       = 8,
    parameter int WIDTH       = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int BW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_we,
    input  logic [AW-1:0]    buf_waddr,
    input  logic [WIDTH-1:0] buf_wdata,
    input  logic [AW-1:0]    buf_raddr,
    output logic [WIDTH-1:0] buf_rdata,
    input  logic [AW-1:0]    burst_len,
    input  logic             master_mode,
    input  logic             cs_gate_en,
    input  logic             start,
    output logic             busy,
    output logic             done,
    input  logic             cs_n_in,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe
);
    import sio_pkg::*;

    sio_state_e        state;
    logic [AW-1:0]     idx;
    logic [AW-1:0]     last_idx;
    logic [BW-1:0]     bit_cnt;
    logic [WIDTH-1:0]  shreg;
    logic              sdo_q;
    logic              done_q;

    logic [2:0]        sync_q;
    logic              sck_prev;
    logic              cs_active;
    logic              gate;
    logic              ext_fall;
    logic              ext_rise;
    sio_edge_t         gen_tick;
    logic              gen_sck;
    logic              ev_fall;
    logic              ev_rise;
    logic              sdi_bit;
    logic [WIDTH-1:0]  shift_in;
    logic              byte_end;
    logic [AW-1:0]     eng_raddr;
    logic [WIDTH-1:0]  eng_rdata;

    // Synchronize data in, chip select and external clock (bits 2..0).
    sio_sync #(
        .N      (3),
        .STAGES (SYNC_STAGES),
        .INIT   (3'b011)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdi, cs_n_in, sck_in}),
        .sync_out (sync_q)
    );

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sync_q[0];
    end

    assign cs_active = ~sync_q[1];
    assign gate      = ~cs_gate_en | cs_active;
    assign ext_fall  = sck_prev & ~sync_q[0];
    assign ext_rise  = ~sck_prev & sync_q[0];

    sio_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy & master_mode),
        .adv   (gate),
        .sck   (gen_sck),
        .tick  (gen_tick)
    );

    assign ev_fall  = busy & gate & (master_mode ? gen_tick.fall : ext_fall);
    assign ev_rise  = busy & gate & (master_mode ? gen_tick.rise : ext_rise);
    assign sdi_bit  = master_mode ? sdi : sync_q[2];
    assign shift_in = {shreg[WIDTH-2:0], sdi_bit};
    assign byte_end = ev_rise && (bit_cnt == BW'(WIDTH - 1));
    assign eng_raddr = (state == ST_RUN) ? idx + AW'(1) : '0;

    sio_buffer #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (buf_we),
        .cpu_waddr (buf_waddr),
        .cpu_wdata (buf_wdata),
        .cpu_raddr (buf_raddr),
        .cpu_rdata (buf_rdata),
        .eng_we    (byte_end),
        .eng_waddr (idx),
        .eng_wdata (shift_in),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata)
    );

    // Burst engine: accept start, launch/capture bits, step through bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            sdo_q    <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        idx      <= '0;
                        last_idx <= burst_len;
                        bit_cnt  <= '0;
                        shreg    <= eng_rdata;
                    end
                end
                default: begin
                    if (ev_fall) sdo_q <= shreg[WIDTH-1];
                    if (ev_rise) begin
                        if (byte_end) begin
                            bit_cnt <= '0;
                            if (idx == last_idx) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                idx   <= idx + AW'(1);
                                shreg <= eng_rdata;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + BW'(1);
                            shreg   <= shift_in;
                        end
                    end
                end
            endcase
        end
    end

    assign busy    = (state == ST_RUN);
    assign done    = done_q;
    assign sck_out = gen_sck;
    assign sck_oe  = master_mode & gate;
    assign sdo     = sdo_q;
    assign sdo_oe  = gate;
endmodule

// File: rtl/sio_burst_port_chk.sv
// Property checker for the buffered serial port, bound to every instance.
// Assumes: sampled on the system clock, quiet during reset.
module sio_burst_port_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic master_mode,
    input logic cs_gate_en,
    input logic cs_active,
    input logic sck_out,
    input logic sck_oe,
    input logic sdo
);
    // R10: completion pulse lasts one cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion coincides with the end of the burst.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: a burst begins only from a start strobe.
    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: clock rests high while idle.
    p_idle_sck_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    // R7: external-clock mode never drives or toggles the local clock.
    p_slave_no_sck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!sck_oe && sck_out));

    // R8: a deselected gated port freezes clock and data.
    p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_gate_en && !cs_active) |=> ($stable(sck_out) && $stable(sdo)));

    if (HALF_DIV > 1) begin : g_phase
        // R6: no clock phase shorter than two system cycles.
        p_min_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !$stable(sck_out)) |=> $stable(sck_out));
    end
endmodule

bind sio_burst_port sio_burst_port_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .master_mode (master_mode),
    .cs_gate_en  (cs_gate_en),
    .cs_active   (cs_active),
    .sck_out     (sck_out),
    .sck_oe      (sck_oe),
    .sdo         (sdo)
);

// File: tb/sio_burst_port_tb.sv
// Bench for the buffered serial port: table-driven bursts against a
// behavioural peer, then directed corner cases.
module sio_burst_port_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       buf_we;
    logic [2:0] buf_waddr;
    logic [7:0] buf_wdata;
    logic [2:0] buf_raddr;
    logic [7:0] buf_rdata;
    logic [2:0] burst_len;
    logic       master_mode, cs_gate_en, start, busy, done;
    logic       cs_n_in, sck_in, sck_out, sck_oe, sdi, sdo, sdo_oe;

    always #4 clk = ~clk;

    sio_burst_port u_dut (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .burst_len(burst_len), .master_mode(master_mode), .cs_gate_en(cs_gate_en),
        .start(start), .busy(busy), .done(done), .cs_n_in(cs_n_in),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int done_bad = 0;
    logic done_prev = 1'b0;
    logic [7:0] cap [8];

    // Vector: {master, cs_gate, len, tx seed, peer seed}
    localparam logic [20:0] VECS [5] = '{
        {1'b1, 1'b0, 3'd0, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 3'd7, 8'h12, 8'hE7},
        {1'b1, 1'b1, 3'd3, 8'h5A, 8'h81},
        {1'b0, 1'b0, 3'd2, 8'hC3, 8'h19},
        {1'b0, 1'b1, 3'd4, 8'h07, 8'hF0}
    };

    function automatic logic [7:0] tx_b(logic [7:0] s, int i);
        return (s + 8'(i * 29)) ^ 8'(i);
    endfunction

    function automatic logic [7:0] px_b(logic [7:0] s, int i);
        return s ^ 8'(i * 53 + 7);
    endfunction

    // Observe completion pulses and their relation to busy (R10).
    always @(negedge clk) begin
        if (done) begin
            done_cnt++;
            if (busy || done_prev) done_bad++;
        end
        done_prev = done;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = a; buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        buf_raddr = a;
        #1 d = buf_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Peer for locally generated clock: drive on fall, capture on rise.
    task automatic master_peer(input int nbytes, input logic [7:0] ps);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] sh;
            logic [7:0] rx;
            sh = px_b(ps, b);
            rx = '0;
            for (int k = 0; k < 8; k++) begin
                while (sck_out !== 1'b0) @(negedge clk);
                sdi = sh[7-k];
                while (sck_out !== 1'b1) @(negedge clk);
                rx = {rx[6:0], sdo};
            end
            cap[b] = rx;
        end
    endtask

    // Peer acting as remote master: generates sck_in itself.
    task automatic slave_peer(input int nbytes, input logic [7:0] ps);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] sh;
            logic [7:0] rx;
            sh = px_b(ps, b);
            rx = '0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                sck_in = 1'b0;
                sdi = sh[7-k];
                repeat (8) @(negedge clk);
                sck_in = 1'b1;
                rx = {rx[6:0], sdo};
                repeat (8) @(negedge clk);
            end
            cap[b] = rx;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic       m, c;
        logic [2:0] len;
        logic [7:0] ts, ps, d;
        int         d0, n;

        rst_n = 1'b0; buf_we = 0; buf_waddr = 0; buf_wdata = 0; buf_raddr = 0;
        burst_len = 0; master_mode = 1; cs_gate_en = 0; start = 0;
        cs_n_in = 1; sck_in = 1; sdi = 0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 sck_out", sck_out, 1);
        check("R1 sdo", sdo, 1);
        rd(3'd5, d);
        check("R1 buffer", d, 0);
        rst_n = 1'b1;

        // R2: buffer write and read back
        for (int i = 0; i < 8; i++) wr(3'(i), 8'(8'h90 + i));
        for (int i = 7; i >= 0; i--) begin
            rd(3'(i), d);
            check("R2 readback", d, 8'(8'h90 + i));
        end

        // Table of bursts
        for (int v = 0; v < 5; v++) begin
            {m, c, len, ts, ps} = VECS[v];
            for (int i = 0; i < 8; i++) wr(3'(i), tx_b(ts, i));
            master_mode = m; cs_gate_en = c; cs_n_in = 1'b0; burst_len = len;
            d0 = done_cnt;
            pulse_start();
            if (m) master_peer(int'(len) + 1, ps);
            else   slave_peer(int'(len) + 1, ps);
            repeat (10) @(negedge clk);
            check("R3 one done per burst", done_cnt - d0, 1);
            check("R10 done shape", done_bad, 0);
            check("R3 idle after burst", busy, 0);
            for (int i = 0; i <= int'(len); i++)
                check("R4 peer received", cap[i], tx_b(ts, i));
            for (int i = 0; i < 8; i++) begin
                rd(3'(i), d);
                if (i <= int'(len)) check("R5 written back", d, px_b(ps, i));
                else                check("R5 untouched", d, tx_b(ts, i));
            end
            check("R7 sck_oe follows mode", sck_oe, m);
            check("R6 sck idle high", sck_out, 1);
        end

        // R6: phase length of the local clock
        master_mode = 1; cs_gate_en = 0; burst_len = 0;
        pulse_start();
        while (sck_out !== 1'b0) @(negedge clk);
        n = 0;
        while (sck_out === 1'b0) begin n++; @(negedge clk); end
        check("R6 low phase", n, HALF);
        n = 0;
        while (sck_out === 1'b1 && busy) begin n++; @(negedge clk); end
        check("R6 high phase", n, HALF);
        while (busy) @(negedge clk);

        // R8: chip select pauses and releases outputs
        for (int i = 0; i < 8; i++) wr(3'(i), tx_b(8'h66, i));
        master_mode = 1; cs_gate_en = 1; cs_n_in = 1; burst_len = 0;
        d0 = done_cnt;
        pulse_start();
        repeat (40) @(negedge clk);
        check("R8 held busy", busy, 1);
        check("R8 sck released", sck_oe, 0);
        check("R8 sdo released", sdo_oe, 0);
        check("R8 no clock", sck_out, 1);
        cs_n_in = 0;
        repeat (4) @(negedge clk);
        check("R8 sck driven", sck_oe, 1);
        check("R8 sdo driven", sdo_oe, 1);
        master_peer(1, 8'h44);
        repeat (10) @(negedge clk);
        check("R8 resumed data", cap[0], tx_b(8'h66, 0));
        check("R8 resumed done", done_cnt - d0, 1);

        // R9: start during a burst is ignored
        for (int i = 0; i < 8; i++) wr(3'(i), tx_b(8'h2B, i));
        cs_gate_en = 0; burst_len = 3'd1;
        d0 = done_cnt;
        pulse_start();
        fork
            master_peer(2, 8'hD2);
            begin
                repeat (20) @(negedge clk);
                burst_len = 3'd7;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (200) @(negedge clk);
        check("R9 single done", done_cnt - d0, 1);
        check("R9 idle", busy, 0);
        check("R9 byte 1 sent", cap[1], tx_b(8'h2B, 1));
        rd(3'd2, d);
        check("R9 entry 2 untouched", d, tx_b(8'h2B, 2));

        summary();
    end
endmodule